// File: doc/BRIEF.md
# Receiver Frame Lock Hunting Controller

This block is the control state machine on the receive side of a serial link. It decides when the receiver has frame lock and when it must search for it again. After reset it sits in acquisition. In that state the clock recovery loop is fed from a local reference clock, and its detector runs in frequency mode. Once the recovery model reports frequency lock, the controller raises its lock status. In the same cycle it moves the detector to phase mode and routes the received data stream to the input.

While it tracks, the controller judges each received frame, one per strobe. A frame is bad if the frame-error input is set. When flag checking is enabled, a frame is also bad if its flag bit repeats the previous frame's flag instead of toggling. Flag checking catches static data that happens to resemble the master transition. A run of consecutive bad frames sends the controller back to reference acquisition, and the hunt starts again. Loss of the serial signal has the same effect at once. A saturating counter tells how many times acquisition has been re-entered since reset.

Top module: `frame_lock_ctrl`

## Requirements
- R1: After reset, `lock_o`, `phase_mode_o` and `src_data_o` are 0 and `reacq_cnt_o` is 0.
- R2: In acquisition all three mode outputs stay 0 for as long as `freq_locked_i` is low. A 0 on `phase_mode_o` means frequency detection, and a 0 on `src_data_o` means the reference clock is the input.
- R3: In acquisition, if `freq_locked_i` is 1 and `sig_loss_i` is 0, then `lock_o`, `phase_mode_o` and `src_data_o` all become 1 together on the next clock edge.
- R4: While tracking, the second bad frame in a row (ERR_LIMIT=2) clears all three mode outputs on the edge that samples it and adds 1 to `reacq_cnt_o`.
- R5: While tracking, a single bad frame does not drop lock, and a good frame resets the run of bad frames to zero.
- R6: When `flag_chk_en_i` is 1, a frame whose `flag_bit_i` equals the flag bit of the previous frame in the same tracking period counts as bad.
- R7: The first frame after the controller enters phase mode only records its flag bit and is never judged bad by the flag check.
- R8: When `flag_chk_en_i` is 0, `flag_bit_i` has no effect on lock.
- R9: `sig_loss_i` at 1 while tracking clears the mode outputs on the next edge and adds 1 to `reacq_cnt_o`. In acquisition it keeps the controller from leaving acquisition.
- R10: `reacq_cnt_o` saturates at 2^CNT_W-1.
- R11: `frame_err_i` and `flag_bit_i` are ignored in cycles where `frame_stb_i` is 0, and always while in acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_locked_i | input | 1 | Frequency lock reported by the clock recovery model |
| frame_stb_i | input | 1 | One-cycle strobe per received frame |
| frame_err_i | input | 1 | Frame error for the strobed frame |
| flag_bit_i | input | 1 | Received flag bit of the strobed frame |
| flag_chk_en_i | input | 1 | Enables the flag alternation check |
| sig_loss_i | input | 1 | Serial signal lost |
| lock_o | output | 1 | Frame lock status |
| phase_mode_o | output | 1 | Detector mode: 1 phase, 0 frequency |
| src_data_o | output | 1 | Input source: 1 data stream, 0 reference clock |
| reacq_cnt_o | output | CNT_W | Saturating count of returns to acquisition |

## Verification
A corrupted bad-frame run count shows at the ports within two frame strobes. Lock either drops one frame too early, after an isolated error, or survives a second consecutive error. A stale alternation record shows on the first checked frame after re-entry to phase mode: that frame is wrongly flagged and lock drops a frame early. A wrong state shows on the very next edge as disagreement between the lock output and the acquisition counter.

// File: rtl/frame_lock_pkg.sv
package frame_lock_pkg;
  typedef enum logic {
    ST_ACQ   = 1'b0,
    ST_TRACK = 1'b1
  } lock_state_e;
endpackage

// File: rtl/flag_alt_chk.sv
// Records the flag of each frame and reports when the current one fails to toggle.
module flag_alt_chk (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic stb,
  input  logic flag_i,
  output logic break_o
);
  logic seeded_q;
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seeded_q <= 1'b0;
      last_q   <= 1'b0;
    end else if (stb) begin
      seeded_q <= 1'b1;
      last_q   <= flag_i;
    end
  end

  assign break_o = seeded_q & (flag_i == last_q);
endmodule

// File: rtl/err_run_cnt.sv
// Counts consecutive bad frames; hit_o marks the frame that reaches the limit.
module err_run_cnt #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic stb,
  input  logic bad,
  output logic hit_o
);
  localparam int RW = $clog2(LIMIT + 1);

  logic [RW-1:0] run_q;

  assign hit_o = stb & bad & (run_q == RW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q <= '0;
    end else if (stb) begin
      if (!bad || hit_o) run_q <= '0;
      else               run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                    q <= '0;
    else if (inc && q != MAXV)  q <= q + 1'b1;
  end
endmodule

// File: rtl/frame_lock_ctrl.sv
module frame_lock_ctrl #(
  parameter int ERR_LIMIT = 2,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freq_locked_i,
  input  logic             frame_stb_i,
  input  logic             frame_err_i,
  input  logic             flag_bit_i,
  input  logic             flag_chk_en_i,
  input  logic             sig_loss_i,
  output logic             lock_o,
  output logic             phase_mode_o,
  output logic             src_data_o,
  output logic [CNT_W-1:0] reacq_cnt_o
);
  import frame_lock_pkg::*;

  lock_state_e state_q;
  logic        tracking;
  logic        trk_stb;
  logic        flag_break;
  logic        frame_bad;
  logic        run_hit;
  logic        enter_trk;
  logic        leave_trk;

  assign tracking  = (state_q == ST_TRACK);
  assign trk_stb   = tracking & frame_stb_i & ~sig_loss_i;
  assign frame_bad = frame_err_i | (flag_chk_en_i & flag_break);
  assign enter_trk = ~tracking & freq_locked_i & ~sig_loss_i;
  assign leave_trk = tracking & (sig_loss_i | run_hit);

  flag_alt_chk u_flag (
    .clk     (clk),
    .rst     (rst),
    .clr     (~tracking),
    .stb     (trk_stb),
    .flag_i  (flag_bit_i),
    .break_o (flag_break)
  );

  err_run_cnt #(.LIMIT(ERR_LIMIT)) u_run (
    .clk   (clk),
    .rst   (rst),
    .clr   (~tracking),
    .stb   (trk_stb),
    .bad   (frame_bad),
    .hit_o (run_hit)
  );

  sat_cnt #(.W(CNT_W)) u_reacq (
    .clk (clk),
    .rst (rst),
    .inc (leave_trk),
    .q   (reacq_cnt_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_ACQ;
      lock_o       <= 1'b0;
      phase_mode_o <= 1'b0;
      src_data_o   <= 1'b0;
    end else if (enter_trk) begin
      state_q      <= ST_TRACK;
      lock_o       <= 1'b1;
      phase_mode_o <= 1'b1;
      src_data_o   <= 1'b1;
    end else if (leave_trk) begin
      state_q      <= ST_ACQ;
      lock_o       <= 1'b0;
      phase_mode_o <= 1'b0;
      src_data_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_lock_ctrl_chk.sv
module frame_lock_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             freq_locked_i,
  input logic             frame_stb_i,
  input logic             sig_loss_i,
  input logic             lock_o,
  input logic             phase_mode_o,
  input logic             src_data_o,
  input logic [CNT_W-1:0] reacq_cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  a_r3_lock_on_freq: assert property (@(posedge clk) disable iff (rst)
    (!lock_o && freq_locked_i && !sig_loss_i) |=> lock_o);

  a_r2_modes_agree: assert property (@(posedge clk) disable iff (rst)
    (lock_o == phase_mode_o) && (lock_o == src_data_o));

  a_r9_loss_drops: assert property (@(posedge clk) disable iff (rst)
    (lock_o && sig_loss_i) |=> !lock_o);

  a_r9_loss_holds_acq: assert property (@(posedge clk) disable iff (rst)
    (!lock_o && sig_loss_i) |=> !lock_o);

  a_r11_no_strobe_keeps_lock: assert property (@(posedge clk) disable iff (rst)
    (lock_o && !frame_stb_i && !sig_loss_i) |=> lock_o);

  a_r4_drop_counts: assert property (@(posedge clk) disable iff (rst)
    ($fell(lock_o) && $past(reacq_cnt_o) != CMAX) |->
      (reacq_cnt_o == CNT_W'($past(reacq_cnt_o) + 1'b1)));

  a_r10_cnt_moves_on_drop: assert property (@(posedge clk) disable iff (rst)
    !$stable(reacq_cnt_o) |-> $fell(lock_o));
endmodule

bind frame_lock_ctrl frame_lock_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .freq_locked_i (freq_locked_i),
  .frame_stb_i   (frame_stb_i),
  .sig_loss_i    (sig_loss_i),
  .lock_o        (lock_o),
  .phase_mode_o  (phase_mode_o),
  .src_data_o    (src_data_o),
  .reacq_cnt_o   (reacq_cnt_o)
);

// File: tb/test_frame_lock_ctrl.sv
module test_frame_lock_ctrl;
  localparam int CW   = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fl = 0, stb = 0, ferr = 0, flag = 0, ce = 0, loss = 0;
  logic lock, phm, src;
  logic [CW-1:0] cnt;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // requirement model
  bit m_lock = 0, m_seed = 0, m_last = 0;
  int m_run = 0, m_cnt = 0;

  always #10 clk = ~clk;

  frame_lock_ctrl #(.ERR_LIMIT(2), .CNT_W(CW)) i_frame_lock_ctrl (
    .clk(clk), .rst(rst), .freq_locked_i(fl), .frame_stb_i(stb),
    .frame_err_i(ferr), .flag_bit_i(flag), .flag_chk_en_i(ce),
    .sig_loss_i(loss), .lock_o(lock), .phase_mode_o(phm),
    .src_data_o(src), .reacq_cnt_o(cnt)
  );

  task automatic check(string tag);
    n_run++;
    if (lock !== m_lock || phm !== m_lock || src !== m_lock || int'(cnt) != m_cnt) begin
      n_fail++;
      $display("FAIL %s: lock/phase/src/cnt = %b%b%b/%0d expected %b%b%b/%0d",
               tag, lock, phm, src, cnt, m_lock, m_lock, m_lock, m_cnt);
    end
  endtask

  task automatic drop();
    m_lock = 0; m_seed = 0; m_run = 0;
    if (m_cnt < CMAX) m_cnt++;
  endtask

  // one cycle: drive after a falling edge, model at the rising edge, check at next falling edge
  task automatic cyc(bit f, bit s, bit e, bit g, bit l, string tag);
    bit bad;
    fl = f; stb = s; ferr = e; flag = g; loss = l;
    @(posedge clk);
    if (!m_lock) begin
      if (f && !l) begin m_lock = 1; m_seed = 0; m_run = 0; end
    end else if (l) begin
      drop();
    end else if (s) begin
      bad = e || (ce && m_seed && (g == m_last));
      m_seed = 1; m_last = g;
      if (bad) begin
        if (m_run + 1 >= 2) drop();
        else m_run++;
      end else m_run = 0;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic acquire(string tag);
    if (!m_lock) cyc(1, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: done=%0d expected 1", done);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1");

    // R2: waiting for frequency lock, R11: frames ignored in acquisition
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, i[0], 0, "R2");
    cyc(0, 1, 1, 1, 0, "R11");
    // R9: signal loss blocks leaving acquisition
    cyc(1, 0, 0, 0, 1, "R9");
    // R3: frequency lock enters phase mode
    cyc(1, 0, 0, 0, 0, "R3");

    // R5: isolated errors separated by good frames keep lock
    ce = 1;
    cyc(0, 1, 1, 0, 0, "R5");
    cyc(0, 1, 0, 1, 0, "R5");
    cyc(0, 1, 1, 0, 0, "R5");
    cyc(0, 0, 1, 0, 0, "R11");
    cyc(0, 1, 0, 1, 0, "R5");
    // R4: two consecutive errors drop lock
    cyc(0, 1, 1, 0, 0, "R4");
    cyc(0, 1, 1, 1, 0, "R4");

    // R7: first frame seeds, R6: static flag is caught
    acquire("R3");
    cyc(0, 1, 0, 1, 0, "R7");
    cyc(0, 1, 0, 1, 0, "R6");
    cyc(0, 1, 0, 1, 0, "R6");

    // R7 again after re-entry: old flag must not matter
    acquire("R3");
    cyc(0, 1, 0, 1, 0, "R7");
    cyc(0, 1, 0, 0, 0, "R7");

    // R8: flag check off, static flag ignored
    ce = 0;
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, "R8");

    // R9: loss while tracking
    cyc(0, 0, 0, 0, 1, "R9");

    // sweep: error and flag-break patterns over three frames, both check modes
    for (int c = 0; c < 2; c++) begin
      ce = c[0];
      for (int p = 0; p < 64; p++) begin
        acquire("R3");
        for (int k = 0; k < 3; k++) begin
          cyc(0, 1, p[k], k[0] ^ p[k+3], 0, "R5");
          cyc(0, 0, 1, p[k], 0, "R11");
        end
      end
    end

    // R10: saturation of the acquisition counter
    for (int i = 0; i < CMAX + 3; i++) begin
      acquire("R3");
      cyc(0, 0, 0, 0, 1, "R10");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule